// File: doc/BRIEF.md
# Bus-Kicked Watchdog Timer

This block watches a two-wire serial bus and uses one specific bus pattern as its keep-alive. The pattern has two parts. First, SDA and SCL must both fall in the same system clock cycle; this arms a pending restart. Second, a stop condition must close that pending restart. The timeout counter is reloaded only at that stop. If the system clock count runs out before the next valid restart, the block drives its fault pin. The pin is open drain, so it is modelled as an active-low level together with a drive-low enable. Both bus lines arrive already synchronised to the system clock. SDA is sampled on every cycle with no gating.

The block has two state machines. The bus pattern machine has the states `BUS_IDLE` and `BUS_ARMED`. Its transition *arm* goes from idle to armed when both lines fall together. Its transition *fire* goes from armed to idle on a stop and emits a one-cycle restart. Its transition *cancel* goes from armed to idle on a start.

The timeout machine has the states `WD_OFF`, `WD_RUN` and `WD_FAULT`. Its transitions are:
- *go*: from off to run when enabled.
- *expire*: from run to fault when the counter is zero.
- *recover*: from fault to run on a restart.
- *disable*: from any state to off when the enable is low.

Four timeout lengths are parameters, and a 2-bit select picks one of them. The select is captured only at a restart or at reset.

Top module: `bus_kick_wdog`

## Requirements
- R1: While `rst` is high, the fault is inactive and any pending candidate is dropped. The counter is reloaded from `tsel`, so a restart-free run after reset faults on the schedule of R3, counted from the first clock edge with `rst` low.
- R2: A valid restart has two parts. First, a candidate: SDA and SCL are both high in one cycle and both low in the next. Later, a stop: SDA goes from low to high while SCL is high in both cycles. The restart takes effect at the clock edge that samples the stop. It reloads the counter and clears an active fault at that edge.
- R3: Let E be the edge of the last restart (or the first enabled edge after reset or re-enable), and let L be the selected count. Then the fault is inactive through edge E+L and active from edge E+L+1.
- R4: When the fault is active, `wdo_n` is 0 and `wdo_oe` is 1. When the fault is inactive, `wdo_n` is 1 and `wdo_oe` is 0.
- R5: After a candidate, a start (SDA falling while SCL is high in both cycles) cancels the pending restart, and a later stop does nothing. A stop with no pending candidate does nothing.
- R6: Once active, the fault stays active while enabled until a valid restart arrives.
- R7: `tsel` values 0, 1, 2 and 3 select `TIMEOUT_0` through `TIMEOUT_3`. The value is captured at a restart or at reset. Changes at any other time do not affect the count in progress.
- R8: When `en` is low, the fault goes inactive at the next edge. The counter is held at the reload value of the last captured select. After `en` returns high, timing restarts per R3.
- R9: An SDA fall while SCL is already low does not form a candidate. The same holds for SDA and SCL falls in different cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Watchdog enable, active high |
| sda | input | 1 | Synchronised serial data line |
| scl | input | 1 | Synchronised serial clock line |
| tsel | input | 2 | Timeout length select |
| wdo_n | output | 1 | Fault level, active low |
| wdo_oe | output | 1 | Drive-low enable for the open-drain fault pin |

## Verification
The assertions assume that `sda` and `scl` are clean, synchronised levels. A candidate is taken to be visible only when both lines fall between two adjacent samples, and `rst` is taken to be held for at least one edge. The stimulus follows these assumptions. It changes the bus lines only at falling clock edges, one pattern step per cycle, and it returns the bus to the idle high/high state between patterns. The select and enable are also moved only at falling edges, so every timing window that is checked starts from a known restart edge.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

    typedef enum logic {
        BUS_IDLE,
        BUS_ARMED
    } bus_st_e;

    typedef enum logic [1:0] {
        WD_OFF,
        WD_RUN,
        WD_FAULT
    } wd_st_e;

endpackage

// File: rtl/wdk_bus_pattern.sv
module wdk_bus_pattern
    import wdk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sda,
    input  logic scl,
    output logic restart
);

    logic    sda_q, scl_q;
    bus_st_e st, st_nxt;

    // previous line levels; idle bus is high/high
    always_ff @(posedge clk) begin
        if (rst) begin
            sda_q <= 1'b1;
            scl_q <= 1'b1;
        end else begin
            sda_q <= sda;
            scl_q <= scl;
        end
    end

    logic sda_fall, scl_fall, cand, start_c, stop_c;
    always_comb begin
        sda_fall = sda_q & ~sda;
        scl_fall = scl_q & ~scl;
        cand     = sda_fall & scl_fall;
        start_c  = sda_fall & scl_q & scl;
        stop_c   = ~sda_q & sda & scl_q & scl;
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            BUS_IDLE:  if (cand) st_nxt = BUS_ARMED;             // arm
            BUS_ARMED: if (stop_c || start_c) st_nxt = BUS_IDLE; // fire / cancel
            default:   st_nxt = BUS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) st <= BUS_IDLE;
        else     st <= st_nxt;
    end

    // outputs
    always_comb begin
        restart = (st == BUS_ARMED) && stop_c;
    end

    // R2: arming only follows a simultaneous fall of both lines
    p_arm_from_candidate_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(st == BUS_ARMED) |-> $past(cand));

    // R5: a start while armed drops the pending candidate
    p_start_cancels_r5: assert property (@(posedge clk) disable iff (rst)
        (st == BUS_ARMED && start_c) |=> (st == BUS_IDLE && !restart));

    // R2: firing consumes the pending candidate
    p_stop_consumes_r2: assert property (@(posedge clk) disable iff (rst)
        restart |=> (st == BUS_IDLE));

endmodule

// File: rtl/wdk_countdown.sv
module wdk_countdown
    import wdk_pkg::*;
#(
    parameter int TO0 = 1000,
    parameter int TO1 = 4000,
    parameter int TO2 = 16000,
    parameter int TO3 = 64000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       restart,
    input  logic [1:0] sel,
    output logic       fault
);

    localparam int MAX01 = (TO0 > TO1) ? TO0 : TO1;
    localparam int MAX23 = (TO2 > TO3) ? TO2 : TO3;
    localparam int MAXT  = (MAX01 > MAX23) ? MAX01 : MAX23;
    localparam int CNT_W = $clog2(MAXT + 1);

    function automatic logic [CNT_W-1:0] pick(input logic [1:0] s);
        unique case (s)
            2'd0: return CNT_W'(TO0);
            2'd1: return CNT_W'(TO1);
            2'd2: return CNT_W'(TO2);
            default: return CNT_W'(TO3);
        endcase
    endfunction

    wd_st_e           st, st_nxt;
    logic [CNT_W-1:0] cnt;
    logic [1:0]       sel_q;

    always_comb begin
        st_nxt = st;
        if (!en) begin
            st_nxt = WD_OFF;                                  // disable
        end else begin
            unique case (st)
                WD_OFF:   st_nxt = WD_RUN;                    // go
                WD_RUN:   if (!restart && cnt == '0) st_nxt = WD_FAULT; // expire
                WD_FAULT: if (restart) st_nxt = WD_RUN;       // recover
                default:  st_nxt = WD_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) st <= WD_OFF;
        else     st <= st_nxt;
    end

    // counter and captured select
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= pick(sel);
            sel_q <= sel;
        end else if (!en) begin
            cnt <= pick(sel_q);
        end else if (restart) begin
            cnt   <= pick(sel);
            sel_q <= sel;
        end else if (st == WD_RUN && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // outputs
    always_comb begin
        fault = (st == WD_FAULT);
    end

    p_reload_on_restart_r2: assert property (@(posedge clk) disable iff (rst)
        (en && restart) |=> (cnt == pick($past(sel)) && st == WD_RUN));

    p_fault_after_zero_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(st == WD_FAULT) |-> ($past(cnt) == '0));

    p_fault_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (st == WD_FAULT && en && !restart) |=> (st == WD_FAULT));

    p_quiet_when_off_r8: assert property (@(posedge clk) disable iff (rst)
        !en |=> (st == WD_OFF && !fault));

    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(MAXT));

endmodule

// File: rtl/bus_kick_wdog.sv
module bus_kick_wdog #(
    parameter int TIMEOUT_0 = 1000,
    parameter int TIMEOUT_1 = 4000,
    parameter int TIMEOUT_2 = 16000,
    parameter int TIMEOUT_3 = 64000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       sda,
    input  logic       scl,
    input  logic [1:0] tsel,
    output logic       wdo_n,
    output logic       wdo_oe
);

    logic restart;
    logic fault;

    wdk_bus_pattern u_pat (
        .clk     (clk),
        .rst     (rst),
        .sda     (sda),
        .scl     (scl),
        .restart (restart)
    );

    wdk_countdown #(
        .TO0 (TIMEOUT_0),
        .TO1 (TIMEOUT_1),
        .TO2 (TIMEOUT_2),
        .TO3 (TIMEOUT_3)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .restart (restart),
        .sel     (tsel),
        .fault   (fault)
    );

    // open-drain pin model (R4)
    always_comb begin
        wdo_oe = fault;
        wdo_n  = ~fault;
    end

    // R4: pin released while disabled
    p_pin_released_off_r4: assert property (@(posedge clk) disable iff (rst)
        !en |=> (wdo_n && !wdo_oe));

endmodule

// File: tb/sim_bus_kick_wdog.sv
module sim_bus_kick_wdog;

    localparam int T0 = 12;
    localparam int T1 = 23;
    localparam int T2 = 37;
    localparam int T3 = 50;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b1;
    logic       sda = 1'b1;
    logic       scl = 1'b1;
    logic [1:0] tsel = 2'd2;
    logic       wdo_n, wdo_oe;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    bus_kick_wdog #(
        .TIMEOUT_0 (T0), .TIMEOUT_1 (T1), .TIMEOUT_2 (T2), .TIMEOUT_3 (T3)
    ) u0 (
        .clk (clk), .rst (rst), .en (en), .sda (sda), .scl (scl),
        .tsel (tsel), .wdo_n (wdo_n), .wdo_oe (wdo_oe)
    );

    function automatic int lim(input int s);
        case (s)
            0: return T0;
            1: return T1;
            2: return T2;
            default: return T3;
        endcase
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // R4: pin pair follows the fault level
    task automatic chk_pins(input string req, input logic f);
        chk({req, " oe"}, wdo_oe, f);
        chk({req, " R4 level"}, wdo_n, ~f);
    endtask

    task automatic step(input logic d, input logic c);
        @(negedge clk);
        sda = d;
        scl = c;
    endtask

    // candidate then stop; the last step's posedge is the restart edge
    task automatic kick();
        step(1, 1); step(0, 0); step(0, 1); step(1, 1);
    endtask

    // called just after driving at negedge N whose next posedge is edge E
    task automatic expect_to(input int L, input int nsel, input string req);
        @(negedge clk);
        chk_pins({req, " early"}, 1'b0);
        tsel = nsel[1:0];
        repeat (L) @(negedge clk);
        chk_pins({req, " R3 at E+L"}, 1'b0);
        @(negedge clk);
        chk_pins({req, " R3 at E+L+1"}, 1'b1);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state, then timing from reset with captured select 2
        repeat (3) @(negedge clk);
        chk_pins("R1 in reset", 1'b0);
        rst = 1'b0;
        expect_to(lim(2), 2, "R1 from reset");

        // R7 / R2 / R3 / R6: sweep captured select vs later select change
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                tsel = a[1:0];
                kick();
                expect_to(lim(a), b, "R7 sweep");
                repeat (7) @(negedge clk);
                chk_pins("R6 sticky", 1'b1);
            end
        end

        // fault active now; R5 start cancels a candidate
        step(0, 0); step(1, 0); step(1, 1); step(0, 1); step(1, 1);
        repeat (2) @(negedge clk);
        chk_pins("R5 cancelled", 1'b1);
        // R5 bare start/stop
        step(0, 1); step(1, 1);
        repeat (2) @(negedge clk);
        chk_pins("R5 bare stop", 1'b1);
        // R9 SDA falls after SCL already low
        step(1, 0); step(0, 0); step(0, 1); step(1, 1);
        repeat (2) @(negedge clk);
        chk_pins("R9 late SDA", 1'b1);
        // R9 SCL falls after SDA (start), then stop
        step(0, 1); step(0, 0); step(0, 1); step(1, 1);
        repeat (2) @(negedge clk);
        chk_pins("R9 split fall", 1'b1);

        // R2 positive control with select 1
        tsel = 2'd1;
        kick();
        expect_to(lim(1), 1, "R2 control");

        // R8 disable while faulted
        en = 1'b0;
        @(negedge clk);
        chk_pins("R8 off next edge", 1'b0);
        tsel = 2'd0;
        repeat (80) @(negedge clk);
        chk_pins("R8 held off", 1'b0);
        en = 1'b1;
        expect_to(lim(1), 0, "R8 re-enable");

        // R1 reset mid-run recaptures select
        tsel = 2'd3;
        kick();
        repeat (5) @(negedge clk);
        tsel = 2'd2;
        rst = 1'b1;
        @(negedge clk);
        chk_pins("R1 mid-run reset", 1'b0);
        rst = 1'b0;
        expect_to(lim(2), 2, "R1 after reset");

        summary();
        $finish;
    end

endmodule